// File: doc/BRIEF.md
# PoE Port Power Command Arbiter

This block turns a one-byte power command into power-enable decisions for a group of Power over Ethernet ports. The default is four ports. Each command byte carries one turn-on bit and one turn-off bit per port. For each port, the block weighs several inputs before it grants a turn-on: the operating mode, a global switch that enables the detection-to-power timing check, the port's own detect and classify enables, the most recent detection and classification results, a per-port window timer, and any fault cool-down that is in progress.

A turn-on request has one of three outcomes: it is granted at once, it is refused with a power-on fault flag, or it is deferred. A deferred request waits for exactly one fresh detection cycle, plus a classification cycle if classification is enabled, and the port is powered only if that cycle succeeds. In semi-automatic mode the block keeps detection running on every port that is unpowered and detect-enabled. It talks to external detection and classification engines through start pulses and done/valid strobes.

A turn-off wipes the port's event, fault, status and enable bits. Every change of the power-enable state or the power-good state produces a one-cycle change strobe.

Top module: `poe_pwr_cmd_arb`

## Requirements
- R1: The mode input is encoded 00 off, 01 manual, 10 semi-automatic, 11 reserved. Command byte bit NPORT+i turns port i off and bit i turns it on. A write made while the mode is 00 or 11 changes nothing.
- R2: If a single write sets both the on bit and the off bit of one port, that port ends up off. Other ports in the same write act on their own bits.
- R3: In manual mode, or whenever the timing check is disabled, a turn-on bit powers the port on the next clock edge, whatever the detection status.
- R4: In semi-automatic mode with the timing check enabled, a port whose detect enable is clear is powered on the next edge.
- R5: In semi-automatic mode with both the timing check and detect enable set, a turn-on request needs three things: the last detection valid, the last classification valid when classify is enabled, and the window still open. An invalid result refuses the request and sets the port's power-on fault bit.
- R6: If the results are valid but the window has expired, the request sets a retry-pending flag and starts a fresh detection cycle. At the end of that cycle the port is powered if the result is valid; otherwise the power-on fault bit is set. The flag then clears, and no further attempt is made.
- R7: A turn-on request is discarded while that port's cool-down input is high or while a disconnect pulse arrives in the same cycle.
- R8: Disconnect, overcurrent, start-fault and current-limit pulses each set their own sticky bit for the port and remove its power.
- R9: A turn-off clears the port's power enable. It also clears the detection and classification events, all four fault bits, the power-on fault bit, the detect status, the class status, both enables and the retry flag.
- R10: The power-good output is the registered AND of the power enable and the sense input. The power-enable and power-good change strobes are high for exactly one cycle after each change of the matching output, and at no other time.
- R11: In semi-automatic mode, an unpowered port with detect enable set starts detection continuously. A valid detection with classify enabled starts classification. The results are latched into the detect status, the 3-bit class status and the event bits.
- R12: The window opens on each valid detection completion and stays open for WIN_TICKS cycles. An invalid detection or a turn-off closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | Operating mode (00 off, 01 manual, 10 semi, 11 reserved) |
| win_chk_en | input | 1 | Enables the detection-to-power timing check |
| en_wr | input | 1 | Loads detect and classify enables |
| en_det_in | input | NPORT | Detect enables to load |
| en_cls_in | input | NPORT | Classify enables to load |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 2*NPORT | Off bits (upper half), on bits (lower half) |
| cool_act | input | NPORT | Fault cool-down in progress |
| disc_evt | input | NPORT | Disconnect pulse |
| icut_evt | input | NPORT | Overcurrent pulse |
| strt_evt | input | NPORT | Start-up fault pulse |
| ilim_evt | input | NPORT | Current-limit pulse |
| pg_sense | input | NPORT | Raw power-good sense |
| det_done | input | NPORT | Detection cycle complete |
| det_valid | input | NPORT | Detection result valid (with det_done) |
| cls_done | input | NPORT | Classification cycle complete |
| cls_valid | input | NPORT | Classification result valid (with cls_done) |
| cls_code_in | input | 3*NPORT | Class code per port (with cls_done) |
| det_start | output | NPORT | Detection start pulse |
| cls_start | output | NPORT | Classification start pulse |
| pwr_en | output | NPORT | Port power enable |
| pwr_good | output | NPORT | Port power good |
| pe_chg | output | NPORT | Power-enable change strobe |
| pg_chg | output | NPORT | Power-good change strobe |
| det_evt | output | NPORT | Detection completed event |
| cls_evt | output | NPORT | Classification completed event |
| disc_flt | output | NPORT | Sticky disconnect fault |
| icut_flt | output | NPORT | Sticky overcurrent fault |
| strt_flt | output | NPORT | Sticky start fault |
| ilim_flt | output | NPORT | Sticky current-limit fault |
| pon_flt | output | NPORT | Power-on request refused |
| det_stat | output | NPORT | Last detection valid |
| cls_stat | output | 3*NPORT | Last valid class code (0 if invalid) |
| det_en | output | NPORT | Detect enable state |
| cls_en | output | NPORT | Classify enable state |
| retry_pend | output | NPORT | Deferred turn-on awaiting fresh detection |

## Verification
Some properties are checked on every cycle. No port gains power while it is in cool-down, during a disconnect, or in a dead mode. A combined on/off write always leaves the port off. Fault pulses and turn-offs remove power, and a turn-off clears every flag. The change strobes track the power enable exactly, the retry flag exists only in semi-automatic mode, and classification starts only right after a valid detection.

Other behaviour depends on a history of engine handshakes and elapsed cycles, so only the bench scenarios can show it. These cases are: whether a request lands inside or outside the window, the deferred retry succeeding or failing, the refusal of a second attempt, and the class code being latched.

// File: rtl/poe_cmd_pkg.sv
`timescale 1ns/1ps
package poe_cmd_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_MAN  = 2'b01,
        MODE_SEMI = 2'b10,
        MODE_RSV  = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'b00,
        ENG_DET  = 2'b01,
        ENG_CLS  = 2'b10
    } eng_e;

    typedef struct packed {
        eng_e             eng;
        logic             pe;
        logic             pg;
        logic             pe_chg;
        logic             pg_chg;
        logic             det_start;
        logic             cls_start;
        logic             det_evt;
        logic             cls_evt;
        logic             disc_flt;
        logic             icut_flt;
        logic             strt_flt;
        logic             ilim_flt;
        logic             pon_flt;
        logic             det_ok;
        logic             cls_ok;
        logic [CLS_W-1:0] cls_code;
        logic             det_en;
        logic             cls_en;
        logic             pend;
        logic             armed;
    } port_st_t;

    function automatic logic mode_live(input logic [1:0] m);
        return (m == MODE_MAN) || (m == MODE_SEMI);
    endfunction

endpackage

// File: rtl/poe_win_timer.sv
`timescale 1ns/1ps
module poe_win_timer #(
    parameter int WIN_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic clear,
    output logic open
);
    localparam int CW = $clog2(WIN_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(WIN_TICKS);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run && (tmr_q.cnt != LIM)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (restart) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end
        if (clear) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign open = tmr_q.run && (tmr_q.cnt < LIM);

endmodule

// File: rtl/poe_port_ctrl.sv
`timescale 1ns/1ps
module poe_port_ctrl
    import poe_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             chk_en,
    input  logic             en_wr,
    input  logic             en_det,
    input  logic             en_cls,
    input  logic             on_req,
    input  logic             off_req,
    input  logic             cool,
    input  logic             disc,
    input  logic             icut,
    input  logic             strt,
    input  logic             ilim,
    input  logic             pg_sense,
    input  logic             det_done,
    input  logic             det_valid,
    input  logic             cls_done,
    input  logic             cls_valid,
    input  logic [CLS_W-1:0] cls_code_in,
    input  logic             win_open,
    output logic             win_restart,
    output logic             win_clear,
    output port_st_t         st
);
    port_st_t st_d, st_q;
    logic     semi;
    logic     resolve;
    logic     resolve_ok;
    logic     any_flt;

    always_comb begin
        st_d           = st_q;
        st_d.det_start = 1'b0;
        st_d.cls_start = 1'b0;
        win_restart    = 1'b0;
        win_clear      = 1'b0;
        resolve        = 1'b0;
        resolve_ok     = 1'b0;
        semi           = (mode == MODE_SEMI);
        any_flt        = disc | icut | strt | ilim;

        // enable loads; a retry cannot outlive semi mode or detect enable
        if (en_wr) begin
            st_d.det_en = en_det;
            st_d.cls_en = en_cls;
        end
        if (!semi || !st_d.det_en) begin
            st_d.pend  = 1'b0;
            st_d.armed = 1'b0;
        end

        // detection / classification engine sequencing
        unique case (st_q.eng)
            ENG_IDLE: begin
                if (semi && st_q.det_en && !st_q.pe) begin
                    st_d.det_start = 1'b1;
                    st_d.eng       = ENG_DET;
                    if (st_d.pend) st_d.armed = 1'b1;
                end
            end
            ENG_DET: begin
                if (det_done) begin
                    st_d.det_evt = 1'b1;
                    st_d.det_ok  = det_valid;
                    win_restart  = det_valid;
                    win_clear    = !det_valid;
                    if (det_valid && st_q.cls_en) begin
                        st_d.cls_start = 1'b1;
                        st_d.cls_ok    = 1'b0;
                        st_d.eng       = ENG_CLS;
                    end else begin
                        st_d.eng   = ENG_IDLE;
                        resolve    = st_q.armed && st_d.pend;
                        resolve_ok = det_valid;
                    end
                end
            end
            ENG_CLS: begin
                if (cls_done) begin
                    st_d.cls_evt  = 1'b1;
                    st_d.cls_ok   = cls_valid;
                    st_d.cls_code = cls_valid ? cls_code_in : '0;
                    st_d.eng      = ENG_IDLE;
                    resolve       = st_q.armed && st_d.pend;
                    resolve_ok    = cls_valid && win_open;
                end
            end
            default: st_d.eng = ENG_IDLE;
        endcase

        // outcome of a deferred request
        if (resolve) begin
            st_d.pend  = 1'b0;
            st_d.armed = 1'b0;
            if (resolve_ok && !cool) st_d.pe      = 1'b1;
            else                     st_d.pon_flt = 1'b1;
        end

        // turn-on command
        if (on_req && !off_req && !cool && !disc && !st_q.pe) begin
            if ((mode == MODE_MAN) || !chk_en || !st_q.det_en) begin
                st_d.pe = 1'b1;
            end else if (!st_q.det_ok || (st_q.cls_en && !st_q.cls_ok)) begin
                st_d.pon_flt = 1'b1;
            end else if (win_open) begin
                st_d.pe = 1'b1;
            end else begin
                st_d.pend  = 1'b1;
                st_d.armed = 1'b0;
                st_d.eng   = ENG_IDLE;
            end
        end
        if (st_d.pe) begin
            st_d.pend  = 1'b0;
            st_d.armed = 1'b0;
        end

        // fault pulses outrank any turn-on
        if (disc) st_d.disc_flt = 1'b1;
        if (icut) st_d.icut_flt = 1'b1;
        if (strt) st_d.strt_flt = 1'b1;
        if (ilim) st_d.ilim_flt = 1'b1;
        if (any_flt) begin
            st_d.pe    = 1'b0;
            st_d.pend  = 1'b0;
            st_d.armed = 1'b0;
        end

        // turn-off command wins over everything
        if (off_req) begin
            st_d.pe        = 1'b0;
            st_d.det_evt   = 1'b0;
            st_d.cls_evt   = 1'b0;
            st_d.disc_flt  = 1'b0;
            st_d.icut_flt  = 1'b0;
            st_d.strt_flt  = 1'b0;
            st_d.ilim_flt  = 1'b0;
            st_d.pon_flt   = 1'b0;
            st_d.det_ok    = 1'b0;
            st_d.cls_ok    = 1'b0;
            st_d.cls_code  = '0;
            st_d.det_en    = 1'b0;
            st_d.cls_en    = 1'b0;
            st_d.pend      = 1'b0;
            st_d.armed     = 1'b0;
            st_d.eng       = ENG_IDLE;
            st_d.det_start = 1'b0;
            st_d.cls_start = 1'b0;
            win_restart    = 1'b0;
            win_clear      = 1'b1;
        end

        st_d.pg     = st_d.pe & pg_sense;
        st_d.pe_chg = st_d.pe != st_q.pe;
        st_d.pg_chg = st_d.pg != st_q.pg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/poe_pwr_cmd_arb.sv
`timescale 1ns/1ps
module poe_pwr_cmd_arb
    import poe_cmd_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int WIN_TICKS = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             op_mode,
    input  logic                   win_chk_en,
    input  logic                   en_wr,
    input  logic [NPORT-1:0]       en_det_in,
    input  logic [NPORT-1:0]       en_cls_in,
    input  logic                   cmd_wr,
    input  logic [2*NPORT-1:0]     cmd_byte,
    input  logic [NPORT-1:0]       cool_act,
    input  logic [NPORT-1:0]       disc_evt,
    input  logic [NPORT-1:0]       icut_evt,
    input  logic [NPORT-1:0]       strt_evt,
    input  logic [NPORT-1:0]       ilim_evt,
    input  logic [NPORT-1:0]       pg_sense,
    input  logic [NPORT-1:0]       det_done,
    input  logic [NPORT-1:0]       det_valid,
    input  logic [NPORT-1:0]       cls_done,
    input  logic [NPORT-1:0]       cls_valid,
    input  logic [CLS_W*NPORT-1:0] cls_code_in,
    output logic [NPORT-1:0]       det_start,
    output logic [NPORT-1:0]       cls_start,
    output logic [NPORT-1:0]       pwr_en,
    output logic [NPORT-1:0]       pwr_good,
    output logic [NPORT-1:0]       pe_chg,
    output logic [NPORT-1:0]       pg_chg,
    output logic [NPORT-1:0]       det_evt,
    output logic [NPORT-1:0]       cls_evt,
    output logic [NPORT-1:0]       disc_flt,
    output logic [NPORT-1:0]       icut_flt,
    output logic [NPORT-1:0]       strt_flt,
    output logic [NPORT-1:0]       ilim_flt,
    output logic [NPORT-1:0]       pon_flt,
    output logic [NPORT-1:0]       det_stat,
    output logic [CLS_W*NPORT-1:0] cls_stat,
    output logic [NPORT-1:0]       det_en,
    output logic [NPORT-1:0]       cls_en,
    output logic [NPORT-1:0]       retry_pend
);
    logic live;
    assign live = cmd_wr && mode_live(op_mode);

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        port_st_t st;
        logic     w_restart;
        logic     w_clear;
        logic     w_open;

        poe_win_timer #(.WIN_TICKS(WIN_TICKS)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (w_restart),
            .clear   (w_clear),
            .open    (w_open)
        );

        poe_port_ctrl u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode        (op_mode),
            .chk_en      (win_chk_en),
            .en_wr       (en_wr),
            .en_det      (en_det_in[i]),
            .en_cls      (en_cls_in[i]),
            .on_req      (live && cmd_byte[i]),
            .off_req     (live && cmd_byte[NPORT+i]),
            .cool        (cool_act[i]),
            .disc        (disc_evt[i]),
            .icut        (icut_evt[i]),
            .strt        (strt_evt[i]),
            .ilim        (ilim_evt[i]),
            .pg_sense    (pg_sense[i]),
            .det_done    (det_done[i]),
            .det_valid   (det_valid[i]),
            .cls_done    (cls_done[i]),
            .cls_valid   (cls_valid[i]),
            .cls_code_in (cls_code_in[i*CLS_W +: CLS_W]),
            .win_open    (w_open),
            .win_restart (w_restart),
            .win_clear   (w_clear),
            .st          (st)
        );

        assign det_start[i]                = st.det_start;
        assign cls_start[i]                = st.cls_start;
        assign pwr_en[i]                   = st.pe;
        assign pwr_good[i]                 = st.pg;
        assign pe_chg[i]                   = st.pe_chg;
        assign pg_chg[i]                   = st.pg_chg;
        assign det_evt[i]                  = st.det_evt;
        assign cls_evt[i]                  = st.cls_evt;
        assign disc_flt[i]                 = st.disc_flt;
        assign icut_flt[i]                 = st.icut_flt;
        assign strt_flt[i]                 = st.strt_flt;
        assign ilim_flt[i]                 = st.ilim_flt;
        assign pon_flt[i]                  = st.pon_flt;
        assign det_stat[i]                 = st.det_ok;
        assign cls_stat[i*CLS_W +: CLS_W]  = st.cls_code;
        assign det_en[i]                   = st.det_en;
        assign cls_en[i]                   = st.cls_en;
        assign retry_pend[i]               = st.pend;
    end

endmodule

// File: rtl/poe_pwr_cmd_arb_chk.sv
`timescale 1ns/1ps
module poe_pwr_cmd_arb_chk #(
    parameter int NPORT = 4,
    parameter int CLS_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             op_mode,
    input logic                   cmd_wr,
    input logic [2*NPORT-1:0]     cmd_byte,
    input logic [NPORT-1:0]       cool_act,
    input logic [NPORT-1:0]       disc_evt,
    input logic [NPORT-1:0]       icut_evt,
    input logic [NPORT-1:0]       strt_evt,
    input logic [NPORT-1:0]       ilim_evt,
    input logic [NPORT-1:0]       det_done,
    input logic [NPORT-1:0]       det_valid,
    input logic [NPORT-1:0]       cls_start,
    input logic [NPORT-1:0]       pwr_en,
    input logic [NPORT-1:0]       pwr_good,
    input logic [NPORT-1:0]       pe_chg,
    input logic [NPORT-1:0]       det_evt,
    input logic [NPORT-1:0]       cls_evt,
    input logic [NPORT-1:0]       disc_flt,
    input logic [NPORT-1:0]       icut_flt,
    input logic [NPORT-1:0]       strt_flt,
    input logic [NPORT-1:0]       ilim_flt,
    input logic [NPORT-1:0]       pon_flt,
    input logic [NPORT-1:0]       det_stat,
    input logic [CLS_W*NPORT-1:0] cls_stat,
    input logic [NPORT-1:0]       det_en,
    input logic [NPORT-1:0]       cls_en,
    input logic [NPORT-1:0]       retry_pend
);
    logic live_wr;
    assign live_wr = cmd_wr && ((op_mode == 2'b01) || (op_mode == 2'b10));

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        assert_power_only_live_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_en[i] && !$past(pwr_en[i])) |-> (($past(op_mode) == 2'b01) || ($past(op_mode) == 2'b10)));

        assert_both_bits_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (live_wr && cmd_byte[i] && cmd_byte[NPORT+i]) |=> !pwr_en[i]);

        assert_cooldown_blocks_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_en[i] && !$past(pwr_en[i])) |-> (!$past(cool_act[i]) && !$past(disc_evt[i])));

        assert_fault_drops_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (disc_evt[i] || icut_evt[i] || strt_evt[i] || ilim_evt[i]) |=> !pwr_en[i]);

        assert_off_clears_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (live_wr && cmd_byte[NPORT+i]) |=>
            (!pwr_en[i] && !det_evt[i] && !cls_evt[i] && !disc_flt[i] && !icut_flt[i] &&
             !strt_flt[i] && !ilim_flt[i] && !pon_flt[i] && !det_stat[i] && !det_en[i] &&
             !cls_en[i] && !retry_pend[i] && (cls_stat[i*CLS_W +: CLS_W] == '0)));

        assert_chg_strobe_only_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pe_chg[i] |-> (pwr_en[i] != $past(pwr_en[i])));

        assert_edge_gives_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_en[i] != $past(pwr_en[i])) |-> pe_chg[i]);

        assert_good_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_good[i] |-> pwr_en[i]);

        assert_retry_only_semi_R6: assert property (@(posedge clk) disable iff (!rst_n)
            retry_pend[i] |-> ($past(op_mode) == 2'b10));

        assert_class_follows_valid_det_R11: assert property (@(posedge clk) disable iff (!rst_n)
            cls_start[i] |-> $past(det_done[i] && det_valid[i]));
    end

endmodule

bind poe_pwr_cmd_arb poe_pwr_cmd_arb_chk #(.NPORT(NPORT), .CLS_W(poe_cmd_pkg::CLS_W)) chk_i (.*);

// File: tb/poe_pwr_cmd_arb_tb_top.sv
`timescale 1ns/1ps
module poe_pwr_cmd_arb_tb_top;
    localparam int NP  = 4;
    localparam int WIN = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     op_mode = 2'b00;
    logic           win_chk_en = 1'b0;
    logic           en_wr = 1'b0;
    logic [NP-1:0]  en_det_in = '0, en_cls_in = '0;
    logic           cmd_wr = 1'b0;
    logic [2*NP-1:0] cmd_byte = '0;
    logic [NP-1:0]  cool_act = '0, disc_evt = '0, icut_evt = '0, strt_evt = '0, ilim_evt = '0;
    logic [NP-1:0]  pg_sense = '0, det_done = '0, det_valid = '0, cls_done = '0, cls_valid = '0;
    logic [3*NP-1:0] cls_code_in = '0;
    logic [NP-1:0]  det_start, cls_start, pwr_en, pwr_good, pe_chg, pg_chg, det_evt, cls_evt;
    logic [NP-1:0]  disc_flt, icut_flt, strt_flt, ilim_flt, pon_flt, det_stat, det_en, cls_en, retry_pend;
    logic [3*NP-1:0] cls_stat;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    poe_pwr_cmd_arb #(.NPORT(NP), .WIN_TICKS(WIN)) dut_i (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        cmd_wr = 1'b1; cmd_byte = b;
        tick();
        cmd_wr = 1'b0; cmd_byte = '0;
    endtask

    task automatic load_en(input logic [3:0] d, input logic [3:0] c);
        en_wr = 1'b1; en_det_in = d; en_cls_in = c;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic pulse_det(input int p, input logic ok);
        det_done[p] = 1'b1; det_valid[p] = ok;
        tick();
        det_done[p] = 1'b0; det_valid[p] = 1'b0;
    endtask

    function automatic logic [3:0] exp_pe(input logic [3:0] prev, input logic [7:0] b,
                                          input logic [1:0] m, input logic [3:0] cool);
        logic [3:0] on_m;
        if (!((m == 2'b01) || (m == 2'b10))) return prev;
        on_m = b[3:0] & ~b[7:4] & ~cool;
        return (prev | on_m) & ~b[7:4];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        logic [7:0] rb;
        logic [1:0] rm;
        logic [3:0] rc;
        void'($urandom(32'd4242));
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk("R9 reset pwr_en", pwr_en, 0);
        chk("R9 reset det_en", det_en, 0);

        // manual mode, immediate turn-on, change strobes
        op_mode = 2'b01; pg_sense = 4'b0001;
        send(8'h05);
        chk("R3 manual on", pwr_en, 4'b0101);
        chk("R10 pe_chg strobe", pe_chg, 4'b0101);
        chk("R10 pwr_good", pwr_good, 4'b0001);
        chk("R10 pg_chg strobe", pg_chg, 4'b0001);
        tick();
        chk("R10 pe_chg one cycle", pe_chg, 0);

        // off mode and reserved mode ignore writes
        op_mode = 2'b00; send(8'hF0);
        chk("R1 off mode ignores", pwr_en, 4'b0101);
        op_mode = 2'b11; send(8'hFF);
        chk("R1 reserved mode ignores", pwr_en, 4'b0101);

        op_mode = 2'b01;
        send(8'h13);
        chk("R2 both bits give off", pwr_en, 4'b0110);

        icut_evt = 4'b0100; tick(); icut_evt = '0;
        chk("R8 overcurrent drops power", pwr_en, 4'b0010);
        chk("R8 overcurrent sticky", icut_flt, 4'b0100);

        cool_act = 4'b1000; send(8'h08); cool_act = '0;
        chk("R7 cool-down blocks on", pwr_en, 4'b0010);
        disc_evt = 4'b1000; send(8'h08); disc_evt = '0;
        chk("R7 disconnect blocks on", pwr_en, 4'b0010);
        chk("R8 disconnect sticky", disc_flt, 4'b1000);

        send(8'hF0);
        chk("R9 off clears power", pwr_en, 0);
        chk("R9 off clears faults", {disc_flt, icut_flt}, 0);

        // random command traffic, no detect enables
        prev = pwr_en;
        for (int k = 0; k < 300; k++) begin
            rb = 8'($urandom); rm = 2'($urandom); rc = 4'($urandom) & 4'($urandom);
            pg_sense = 4'($urandom);
            op_mode = rm; cool_act = rc;
            send(rb);
            prev = exp_pe(prev, rb, rm, rc);
            chk("R3 random pwr_en", pwr_en, prev);
            chk("R10 random pwr_good", pwr_good, prev & pg_sense);
        end
        cool_act = '0; pg_sense = '0;
        op_mode = 2'b01; send(8'hF0);

        // semi-automatic with timing check
        op_mode = 2'b10; win_chk_en = 1'b1;
        load_en(4'b0001, 4'b0001);
        chk("R11 detect enable loaded", det_en, 4'b0001);
        tick();
        chk("R11 detection auto start", det_start[0], 1);
        pulse_det(0, 1'b1);
        chk("R11 detect status", det_stat[0], 1);
        chk("R11 class start after det", cls_start[0], 1);
        cls_done[0] = 1'b1; cls_valid[0] = 1'b1; cls_code_in[2:0] = 3'd5;
        tick();
        cls_done[0] = 1'b0; cls_valid[0] = 1'b0; cls_code_in = '0;
        chk("R11 class code latched", cls_stat[2:0], 3'd5);
        chk("R11 class event", cls_evt[0], 1);
        tick();
        send(8'h01);
        chk("R5 in-window on", pwr_en[0], 1);

        load_en(4'b0011, 4'b0001);
        tick();
        pulse_det(1, 1'b0);
        send(8'h02);
        chk("R5 invalid det refused", pwr_en[1], 0);
        chk("R5 power-on fault", pon_flt[1], 1);

        // expired window: deferred retry succeeds
        load_en(4'b0111, 4'b0001);
        tick();
        pulse_det(2, 1'b1);
        repeat (30) tick();
        send(8'h04);
        chk("R6 retry pending", retry_pend[2], 1);
        chk("R12 expired no power", pwr_en[2], 0);
        tick();
        chk("R6 fresh detection", det_start[2], 1);
        pulse_det(2, 1'b1);
        chk("R6 retry powers", pwr_en[2], 1);
        chk("R6 retry flag cleared", retry_pend[2], 0);

        // expired window: deferred retry fails, no second try
        load_en(4'b1111, 4'b0001);
        tick();
        pulse_det(3, 1'b1);
        repeat (30) tick();
        send(8'h08);
        chk("R6 second retry pending", retry_pend[3], 1);
        tick();
        pulse_det(3, 1'b0);
        chk("R6 failed retry fault", pon_flt[3], 1);
        chk("R6 failed retry flag", retry_pend[3], 0);
        tick();
        pulse_det(3, 1'b1);
        tick();
        chk("R6 no further attempt", pwr_en[3], 0);

        repeat (10) tick();
        send(8'h08);
        chk("R12 inside window on", pwr_en[3], 1);

        send(8'hF0);
        chk("R9 semi off power", pwr_en, 0);
        chk("R9 semi off enables", {det_en, cls_en}, 0);
        chk("R9 semi off status", {det_stat, pon_flt, det_evt}, 0);
        chk("R9 semi off class", cls_stat, 0);

        send(8'h02);
        chk("R4 semi detect disabled on", pwr_en, 4'b0010);

        win_chk_en = 1'b0;
        load_en(4'b0001, 4'b0000);
        send(8'h01);
        chk("R3 timing check off on", pwr_en[0], 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule